// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. Software programs it through a small register window: a source address, a destination address, a transfer count and a control word. Each pulse on the transfer strobe makes the channel move exactly one transfer unit. It reads the unit from the source and writes it to the destination over a request/acknowledge memory port. It then steps each address by the unit size as the control word's modes require, decrements the count, and writes all three values back into the registers.

The control word selects the unit size, the stepping mode for each side, and which sides are devices rather than memory. A device side gets no memory access and its address does not move. The channel only accepts a strobe when it is enabled, has not yet finished, and the shared global operation value presented at its input permits DMA. When the count runs out, the channel sets its transfer-end bit. If interrupts are enabled, it then holds its interrupt line high until software clears either of those bits with a control write.

Top module: `dma_chan_engine`

## Requirements
- R1: After synchronous reset all four registers read zero, `mem_req` is low and `irq` is low.
- R2: The register window is decoded on `cfg_addr`: 0x0 source address, 0x4 destination address, 0x8 count (24 bits, upper bits read as zero), 0xC control (16 bits, upper bits read as zero). A write whose `cfg_addr[1:0]` is not 00 changes nothing.
- R3: A strobe starts a transfer only when control bit 0 (enable) is 1, control bit 1 (transfer end) is 0 and `glb_op` equals 3'b001. Otherwise the strobe is ignored: no memory request and no register change.
- R4: Control bits [6:4] give the unit size in bytes, shown on `mem_bytes`: code 0 is 8, 1 is 1, 2 is 2, 3 is 4, 4 is 32, and codes 5, 6 and 7 are 1.
- R5: Control bits [13:12] are the source address mode and bits [15:14] the destination address mode. Mode 0 keeps the address, mode 1 adds the unit size and mode 2 subtracts it.
- R6: If either address mode is 3, the strobe is ignored: no memory request and no register change.
- R7: A transfer with both sides in memory issues one read (`mem_write`=0) at the source address and then one write (`mem_write`=1) at the destination address. Each request is held until `mem_ack`, and the write data equals the data returned by the read.
- R8: Control bits [11:8] form a request-source code. If its bit 1 is set, the source is a device: no read is issued and the source address is left unchanged. If its bit 0 is set, the destination is a device: no write is issued and the destination address is left unchanged.
- R9: After each transfer the count register holds the previous count minus one. A programmed count of zero is treated as 2^24, so it becomes 0xFFFFFF.
- R10: When a transfer brings the count to zero, control bit 1 is set. `irq` is high exactly while control bit 2 (interrupt enable) and bit 1 are both set.
- R11: A control write that clears bit 2 or bit 1 drops `irq` on the next cycle.
- R12: Address stepping wraps modulo 2^32 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Byte offset for register read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data at `cfg_addr` |
| glb_op | input | 3 | Shared global DMA operation value |
| xfer_strobe | input | 1 | One-transfer request pulse |
| mem_req | output | 1 | Memory access request |
| mem_write | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Memory access address |
| mem_bytes | output | 6 | Bytes in the current unit |
| mem_wdata | output | 32 | Write data (captured read data) |
| mem_rdata | input | 32 | Read data returned with acknowledge |
| mem_ack | input | 1 | Memory access acknowledge |
| irq | output | 1 | Level channel interrupt |

## Verification
The transfer path is driven with several distinct control words: incrementing on both sides, decrementing source with a fixed destination, and several size codes. These separate the per-side mode decoding and the size table, which a swapped field or a wrong entry would expose. Address values near both ends of the 32-bit range show whether stepping wraps. Counts of zero, one and larger values tell the 2^24 rule and the completion condition apart. Device codes of 1, 2 and 3 check which memory phases are skipped. Disabled, finished, wrong-global-value and illegal-mode cases must leave every register and the memory port untouched.

// File: rtl/dce_pkg.sv
package dce_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_UPD  = 2'd3
    } dce_state_e;

    typedef enum logic [1:0] {
        AM_FIXED = 2'd0,
        AM_INC   = 2'd1,
        AM_DEC   = 2'd2,
        AM_BAD   = 2'd3
    } dce_amode_e;

    // control word layout, bit 15 down to bit 0
    typedef struct packed {
        dce_amode_e dst_mode;   // 15:14
        dce_amode_e src_mode;   // 13:12
        logic [1:0] rsv_hi;     // 11:10
        logic       src_dev;    // 9
        logic       dst_dev;    // 8
        logic       rsv7;       // 7
        logic [2:0] size_code;  // 6:4
        logic       rsv3;       // 3
        logic       ie;         // 2
        logic       te;         // 1
        logic       en;         // 0
    } dce_ctrl_t;

    localparam int BYTES_W = 6;

    function automatic logic [BYTES_W-1:0] unit_bytes(input logic [2:0] code);
        case (code)
            3'd0:    unit_bytes = 6'd8;
            3'd2:    unit_bytes = 6'd2;
            3'd3:    unit_bytes = 6'd4;
            3'd4:    unit_bytes = 6'd32;
            default: unit_bytes = 6'd1;
        endcase
    endfunction

    localparam logic [2:0] GLB_RUN = 3'b001;

endpackage

// File: rtl/dce_regs.sv
module dce_regs
    import dce_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [3:0]       off,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             upd_en,
    input  logic [REG_W-1:0] upd_sar,
    input  logic [REG_W-1:0] upd_dar,
    input  logic [CNT_W-1:0] upd_tcr,
    input  logic             upd_last,
    output logic [REG_W-1:0] sar,
    output logic [REG_W-1:0] dar,
    output logic [CNT_W-1:0] tcr,
    output logic [15:0]      ctrl
);
    localparam logic [1:0] SEL_SAR = 2'd0;
    localparam logic [1:0] SEL_DAR = 2'd1;
    localparam logic [1:0] SEL_TCR = 2'd2;
    localparam logic [1:0] SEL_CTL = 2'd3;

    logic wr_hit;
    assign wr_hit = wr_en && (off[1:0] == 2'b00);

    always_ff @(posedge clk) begin
        if (rst) begin
            sar  <= '0;
            dar  <= '0;
            tcr  <= '0;
            ctrl <= '0;
        end else begin
            // channel write-back has priority over a software write
            if (upd_en)                              sar <= upd_sar;
            else if (wr_hit && off[3:2] == SEL_SAR)  sar <= wr_data;
            if (upd_en)                              dar <= upd_dar;
            else if (wr_hit && off[3:2] == SEL_DAR)  dar <= wr_data;
            if (upd_en)                              tcr <= upd_tcr;
            else if (wr_hit && off[3:2] == SEL_TCR)  tcr <= wr_data[CNT_W-1:0];
            if (wr_hit && off[3:2] == SEL_CTL)       ctrl <= wr_data[15:0];
            if (upd_en && upd_last)                  ctrl[1] <= 1'b1;
        end
    end

    always_comb begin
        case (off[3:2])
            SEL_SAR: rd_data = sar;
            SEL_DAR: rd_data = dar;
            SEL_TCR: rd_data = REG_W'(tcr);
            default: rd_data = REG_W'(ctrl);
        endcase
    end

    // R9: every completed transfer moves the count
    a_r9_count_moves: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> (tcr != $past(tcr)));

endmodule

// File: rtl/dce_next.sv
module dce_next
    import dce_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int CNT_W = 24
) (
    input  logic [REG_W-1:0]   sar,
    input  logic [REG_W-1:0]   dar,
    input  logic [CNT_W-1:0]   tcr,
    input  dce_amode_e         src_mode,
    input  dce_amode_e         dst_mode,
    input  logic               src_dev,
    input  logic               dst_dev,
    input  logic [2:0]         size_code,
    output logic [REG_W-1:0]   nsar,
    output logic [REG_W-1:0]   ndar,
    output logic [CNT_W-1:0]   ntcr,
    output logic               last,
    output logic [BYTES_W-1:0] bytes
);
    localparam logic [CNT_W:0] FULL_CNT = {1'b1, {CNT_W{1'b0}}};

    function automatic logic [REG_W-1:0] step(input logic [REG_W-1:0] a,
                                              input dce_amode_e m,
                                              input logic dev,
                                              input logic [BYTES_W-1:0] b);
        if (dev) return a;
        case (m)
            AM_INC:  return a + REG_W'(b);
            AM_DEC:  return a - REG_W'(b);
            default: return a;
        endcase
    endfunction

    logic [CNT_W:0] full;
    logic [CNT_W:0] rem;

    assign bytes = unit_bytes(size_code);
    assign nsar  = step(sar, src_mode, src_dev, bytes);
    assign ndar  = step(dar, dst_mode, dst_dev, bytes);
    assign full  = (tcr == '0) ? FULL_CNT : {1'b0, tcr};
    assign rem   = full - 1'b1;
    assign ntcr  = rem[CNT_W-1:0];
    assign last  = (rem == '0);

endmodule

// File: rtl/dce_fsm.sv
module dce_fsm
    import dce_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic              runnable,
    input  logic              legal,
    input  logic              src_mem,
    input  logic              dst_mem,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output dce_state_e        st,
    output logic              mem_req,
    output logic              mem_write,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              upd_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            mem_wdata <= '0;
        end else begin
            case (st)
                ST_IDLE: if (strobe && runnable && legal)
                    st <= src_mem ? ST_RD : (dst_mem ? ST_WR : ST_UPD);
                ST_RD: if (mem_ack) begin
                    mem_wdata <= mem_rdata;
                    st        <= dst_mem ? ST_WR : ST_UPD;
                end
                ST_WR: if (mem_ack) st <= ST_UPD;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign mem_req   = (st == ST_RD) || (st == ST_WR);
    assign mem_write = (st == ST_WR);
    assign upd_en    = (st == ST_UPD);

    // R3: a strobe on a channel that may not run leaves it idle
    a_r3_gate_blocks: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && strobe && !runnable) |=> (st == ST_IDLE));
    // R6: illegal address modes block the start
    a_r6_illegal_blocks: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && strobe && !legal) |=> (st == ST_IDLE));
    // R7: a request stays up until acknowledged
    a_r7_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_write)));

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dce_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int CNT_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [3:0]         cfg_addr,
    input  logic [REG_W-1:0]   cfg_wdata,
    output logic [REG_W-1:0]   cfg_rdata,
    input  logic [2:0]         glb_op,
    input  logic               xfer_strobe,
    output logic               mem_req,
    output logic               mem_write,
    output logic [REG_W-1:0]   mem_addr,
    output logic [BYTES_W-1:0] mem_bytes,
    output logic [REG_W-1:0]   mem_wdata,
    input  logic [REG_W-1:0]   mem_rdata,
    input  logic               mem_ack,
    output logic               irq
);
    logic [REG_W-1:0] sar, dar, nsar, ndar;
    logic [CNT_W-1:0] tcr, ntcr;
    logic [15:0]      ctrl_w;
    dce_ctrl_t        cw;
    logic             last, upd_en, runnable, legal;
    dce_state_e       st;
    logic             unused_ctrl_bits;

    assign cw               = dce_ctrl_t'(ctrl_w);
    assign unused_ctrl_bits = ^{cw.rsv_hi, cw.rsv7, cw.rsv3};
    assign runnable         = cw.en && !cw.te && (glb_op == GLB_RUN);
    assign legal            = (cw.src_mode != AM_BAD) && (cw.dst_mode != AM_BAD);
    assign irq              = cw.ie && cw.te;

    dce_regs #(.REG_W(REG_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(cfg_we), .off(cfg_addr), .wr_data(cfg_wdata), .rd_data(cfg_rdata),
        .upd_en(upd_en), .upd_sar(nsar), .upd_dar(ndar), .upd_tcr(ntcr),
        .upd_last(last),
        .sar(sar), .dar(dar), .tcr(tcr), .ctrl(ctrl_w)
    );

    dce_next #(.REG_W(REG_W), .CNT_W(CNT_W)) u_next (
        .sar(sar), .dar(dar), .tcr(tcr),
        .src_mode(cw.src_mode), .dst_mode(cw.dst_mode),
        .src_dev(cw.src_dev), .dst_dev(cw.dst_dev), .size_code(cw.size_code),
        .nsar(nsar), .ndar(ndar), .ntcr(ntcr), .last(last), .bytes(mem_bytes)
    );

    dce_fsm #(.DATA_W(REG_W)) u_fsm (
        .clk(clk), .rst(rst), .strobe(xfer_strobe),
        .runnable(runnable), .legal(legal),
        .src_mem(!cw.src_dev), .dst_mem(!cw.dst_dev),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .st(st), .mem_req(mem_req), .mem_write(mem_write),
        .mem_wdata(mem_wdata), .upd_en(upd_en)
    );

    assign mem_addr = (st == ST_RD) ? sar : dar;

    // R10: the final transfer of a block raises transfer end
    a_r10_te_on_last: assert property (@(posedge clk) disable iff (rst)
        (upd_en && tcr == CNT_W'(1)) |=> cw.te);
    // R8: a device source never produces a read
    a_r8_dev_src_no_read: assert property (@(posedge clk) disable iff (rst)
        (cw.src_dev && $stable(ctrl_w) && st == ST_IDLE) |=> !(mem_req && !mem_write));

endmodule

// File: tb/dma_chan_engine_tb.sv
`timescale 1ns/1ps
module dma_chan_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = 4'h0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [2:0]  glb_op = 3'b001;
    logic        xfer_strobe = 1'b0;
    logic        mem_req, mem_write;
    logic [31:0] mem_addr, mem_wdata;
    logic [5:0]  mem_bytes;
    logic [31:0] mem_rdata = 32'hC0DE_0000;
    logic        mem_ack = 1'b0;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int          nrd, nwr;
    logic [31:0] rda, wra, wdat;
    logic [5:0]  nbytes;

    always #2.5 clk = ~clk;

    dma_chan_engine u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .glb_op(glb_op),
        .xfer_strobe(xfer_strobe), .mem_req(mem_req), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_bytes(mem_bytes), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wrreg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rdreg(input logic [3:0] a, output logic [31:0] v);
        cfg_addr = a;
        #1;
        v = cfg_rdata;
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] d,
                         input logic [31:0] c, input logic [31:0] k);
        wrreg(4'h0, s); wrreg(4'h4, d); wrreg(4'h8, c); wrreg(4'hC, k);
    endtask

    task automatic xfer();
        nrd = 0; nwr = 0; rda = '0; wra = '0; wdat = '0; nbytes = '0;
        mem_rdata = mem_rdata + 32'h11;
        @(negedge clk);
        xfer_strobe = 1'b1;
        @(negedge clk);
        xfer_strobe = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (mem_write) begin nwr++; wra = mem_addr; wdat = mem_wdata; end
                else begin nrd++; rda = mem_addr; end
                nbytes  = mem_bytes;
                mem_ack = 1'b1;
            end
            @(negedge clk);
        end
        mem_ack = 1'b0;
    endtask

    task automatic expect_regs(input string req, input logic [31:0] s, input logic [31:0] d,
                               input logic [31:0] c, input logic [31:0] k);
        logic [31:0] v;
        rdreg(4'h0, v); check({req, " src"}, v, s);
        rdreg(4'h4, v); check({req, " dst"}, v, d);
        rdreg(4'h8, v); check({req, " count"}, v, c);
        rdreg(4'hC, v); check({req, " ctrl"}, v, k);
    endtask

    task automatic expect_ignored(input string req, input logic [31:0] s, input logic [31:0] d,
                                  input logic [31:0] c, input logic [31:0] k);
        xfer();
        check({req, " reads"}, nrd, 0);
        check({req, " writes"}, nwr, 0);
        expect_regs(req, s, d, c, k);
    endtask

    task automatic t_reset();
        check("R1 mem_req", mem_req, 0);
        check("R1 irq", irq, 0);
        expect_regs("R1", 0, 0, 0, 0);
        wrreg(4'h0, 32'h1234_5678);
        wrreg(4'h9, 32'h0000_0077);
        wrreg(4'h8, 32'hAB12_3456);
        wrreg(4'hC, 32'hFFFF_0000);
        expect_regs("R2", 32'h1234_5678, 0, 32'h0012_3456, 0);
    endtask

    task automatic t_inc();
        setup(32'h1000, 32'h2000, 5, 32'h5031);
        xfer();
        check("R7 reads", nrd, 1);
        check("R7 writes", nwr, 1);
        check("R7 read addr", rda, 32'h1000);
        check("R7 write addr", wra, 32'h2000);
        check("R7 data", wdat, mem_rdata);
        check("R4 bytes code3", nbytes, 4);
        expect_regs("R5 inc", 32'h1004, 32'h2004, 4, 32'h5031);
    endtask

    task automatic t_dec_fixed();
        setup(32'h800, 32'h3000, 9, 32'h2041);
        xfer();
        check("R4 bytes code4", nbytes, 32);
        expect_regs("R5 dec/fixed", 32'h7E0, 32'h3000, 8, 32'h2041);
    endtask

    task automatic t_sizes();
        setup(32'h100, 32'h200, 3, 32'h5001);
        xfer();
        check("R4 bytes code0", nbytes, 8);
        expect_regs("R4 code0", 32'h108, 32'h208, 2, 32'h5001);
        setup(32'h100, 32'h200, 3, 32'h5061);
        xfer();
        check("R4 bytes code6", nbytes, 1);
        expect_regs("R4 code6", 32'h101, 32'h201, 2, 32'h5061);
    endtask

    task automatic t_wrap();
        setup(32'hFFFF_FFFC, 32'h4, 2, 32'h9001);
        xfer();
        expect_regs("R12 wrap", 32'h4, 32'hFFFF_FFFC, 1, 32'h9001);
    endtask

    task automatic t_count_end();
        setup(32'h0, 32'h40, 0, 32'h5035);
        xfer();
        expect_regs("R9 zero count", 32'h4, 32'h44, 32'h00FF_FFFF, 32'h5035);
        check("R10 no irq mid-block", irq, 0);
        setup(32'h0, 32'h40, 1, 32'h5035);
        xfer();
        expect_regs("R10 last", 32'h4, 32'h44, 0, 32'h5037);
        check("R10 irq high", irq, 1);
        expect_ignored("R3 after end", 32'h4, 32'h44, 0, 32'h5037);
        wrreg(4'hC, 32'h5033);
        check("R11 IE cleared", irq, 0);
        wrreg(4'hC, 32'h5037);
        check("R10 irq both set", irq, 1);
        wrreg(4'hC, 32'h5035);
        check("R11 TE cleared", irq, 0);
    endtask

    task automatic t_gate();
        setup(32'h500, 32'h600, 4, 32'h5031);
        glb_op = 3'b011;
        expect_ignored("R3 glb 011", 32'h500, 32'h600, 4, 32'h5031);
        glb_op = 3'b000;
        expect_ignored("R3 glb 000", 32'h500, 32'h600, 4, 32'h5031);
        glb_op = 3'b001;
        wrreg(4'hC, 32'h5030);
        expect_ignored("R3 disabled", 32'h500, 32'h600, 4, 32'h5030);
    endtask

    task automatic t_illegal();
        setup(32'h500, 32'h600, 4, 32'h7031);
        expect_ignored("R6 src mode3", 32'h500, 32'h600, 4, 32'h7031);
        wrreg(4'hC, 32'hD031);
        expect_ignored("R6 dst mode3", 32'h500, 32'h600, 4, 32'hD031);
    endtask

    task automatic t_device();
        setup(32'h900, 32'hA00, 6, 32'h5231);
        xfer();
        check("R8 src dev reads", nrd, 0);
        check("R8 src dev writes", nwr, 1);
        check("R8 src dev waddr", wra, 32'hA00);
        expect_regs("R8 src dev", 32'h900, 32'hA04, 5, 32'h5231);
        setup(32'h900, 32'hA00, 6, 32'h5131);
        xfer();
        check("R8 dst dev reads", nrd, 1);
        check("R8 dst dev writes", nwr, 0);
        check("R8 dst dev raddr", rda, 32'h900);
        expect_regs("R8 dst dev", 32'h904, 32'hA00, 5, 32'h5131);
        setup(32'h900, 32'hA00, 6, 32'h5331);
        xfer();
        check("R8 both dev reads", nrd, 0);
        check("R8 both dev writes", nwr, 0);
        expect_regs("R8 both dev", 32'h900, 32'hA00, 5, 32'h5331);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_inc();
        t_dec_fixed();
        t_sizes();
        t_wrap();
        t_count_end();
        t_gate();
        t_illegal();
        t_device();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule